// File: doc/BRIEF.md
# Two-bit up/down counter with prioritized clear and enable

This block is a small Moore-style counter that steps through four states, S0 to S3, in either direction. Three control inputs are sampled on each rising clock edge and act in a fixed order of precedence. The active-low clear comes first. The active-low enable comes second. The direction select comes last. The count output is the state register itself, so it changes only right after a clock edge.

Internally the next value is chosen by a four-way selector. Its two select lines are the clear and enable inputs. Its data inputs are the cleared value, the present state, and the incremented or decremented present state. The multi-bit selector is built one bit at a time from single-bit four-way selectors, and each of those is made of three single-bit two-way selectors. Width is a parameter that defaults to 2.

Top module: `updn_counter`

## Requirements
- R1: When clr_n is 0 at a rising edge, count becomes 0 (state S0) after that edge, whatever the values of go_n and down.
- R2: When clr_n is 1 and go_n is 1 at a rising edge, count keeps its value.
- R3: When clr_n is 1, go_n is 0 and down is 0, count becomes its previous value plus one.
- R4: Counting up from 3 (binary 11) gives 0.
- R5: When clr_n is 1, go_n is 0 and down is 1, count becomes its previous value minus one.
- R6: Counting down from 0 gives 3 (binary 11).
- R7: count is the state register (S0=0, S1=1, S2=2, S3=3). Input changes between edges have no effect on count until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| go_n | input | 1 | Count enable, active low; 1 holds the state |
| down | input | 1 | Direction: 0 counts up, 1 counts down |
| count | output | W (2) | Present state, binary encoded |

## Verification
The output is the state register, so a wrong next state shows at count one clock after the faulty edge. A wrong selector leg shows up as a hold where a step was expected, or a step where a hold or clear was expected. A fault in the adder or subtractor appears only in the matching direction, and a wrap fault appears only from state 3 going up or from state 0 going down. The bench therefore drives every clear, enable and direction combination from each of the four states. It compares count with a reference model after every edge.

// File: rtl/updn_pkg.sv
package updn_pkg;
  // select = {clr_n, go_n}
  localparam logic [1:0] SEL_CLR_A = 2'b00;
  localparam logic [1:0] SEL_CLR_B = 2'b01;
  localparam logic [1:0] SEL_STEP  = 2'b10;
  localparam logic [1:0] SEL_KEEP  = 2'b11;
endpackage

// File: rtl/updn_mux2_bit.sv
module updn_mux2_bit (
  input  logic a,
  input  logic b,
  input  logic s,
  output logic y
);
  always_comb y = s ? b : a;
endmodule

// File: rtl/updn_mux4_bit.sv
module updn_mux4_bit (
  input  logic [3:0] d,
  input  logic [1:0] s,
  output logic       y
);
  logic lo, hi;
  updn_mux2_bit u_lo  (.a(d[0]), .b(d[1]), .s(s[0]), .y(lo));
  updn_mux2_bit u_hi  (.a(d[2]), .b(d[3]), .s(s[0]), .y(hi));
  updn_mux2_bit u_out (.a(lo),   .b(hi),   .s(s[1]), .y(y));
endmodule

// File: rtl/updn_mux4_vec.sv
module updn_mux4_vec #(
  parameter int W = 2
) (
  input  logic [W-1:0] d0,
  input  logic [W-1:0] d1,
  input  logic [W-1:0] d2,
  input  logic [W-1:0] d3,
  input  logic [1:0]   s,
  output logic [W-1:0] y
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    updn_mux4_bit u_m (.d({d3[i], d2[i], d1[i], d0[i]}), .s(s), .y(y[i]));
  end
endmodule

// File: rtl/updn_step.sv
module updn_step #(
  parameter int W = 2
) (
  input  logic [W-1:0] cur,
  input  logic         down,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] ONE = W'(1);
  logic [W-1:0] inc, dec;
  always_comb begin
    inc = cur + ONE;
    dec = cur - ONE;
  end
  updn_mux4_vec #(.W(W)) u_dir (
    .d0(inc), .d1(dec), .d2(inc), .d3(dec), .s({1'b0, down}), .y(nxt)
  );
endmodule

// File: rtl/updn_counter.sv
module updn_counter #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         go_n,
  input  logic         down,
  output logic [W-1:0] count
);
  import updn_pkg::*;
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] TOP  = '1;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] state_q, stepped, next_d;
  logic [1:0]   sel;

  always_comb sel = {clr_n, go_n};

  updn_step #(.W(W)) u_step (.cur(state_q), .down(down), .nxt(stepped));

  // leg order follows select encoding in updn_pkg
  updn_mux4_vec #(.W(W)) u_sel (
    .d0(ZERO), .d1(ZERO), .d2(stepped), .d3(state_q), .s(sel), .y(next_d)
  );

  always_ff @(posedge clk) state_q <= next_d;

  always_comb count = state_q;

  // checks armed once the state has been cleared at least once
  logic armed = 1'b0;
  always_ff @(posedge clk) if (sel == SEL_CLR_A || sel == SEL_CLR_B) armed <= 1'b1;

  p_clear_r1: assert property (@(posedge clk) disable iff (!armed)
    !clr_n |=> count == ZERO);
  p_hold_r2: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && go_n) |=> $stable(count));
  p_up_r3: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && !go_n && !down) |=> count == $past(count) + ONE);
  p_upwrap_r4: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && !go_n && !down && count == TOP) |=> count == ZERO);
  p_dn_r5: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && !go_n && down) |=> count == $past(count) - ONE);
  p_dnwrap_r6: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && !go_n && down && count == ZERO) |=> count == TOP);
endmodule

// File: tb/test_updn_counter.sv
module test_updn_counter;
  logic clk = 1'b0;
  logic clr_n = 1'b1, go_n = 1'b1, down = 1'b0;
  logic [1:0] count;
  int total = 0, bad = 0;
  int mdl = 0;

  always #5 clk = ~clk;

  updn_counter #(.W(2)) i_updn_counter (
    .clk(clk), .clr_n(clr_n), .go_n(go_n), .down(down), .count(count)
  );

  task automatic step(input logic c, input logic g, input logic d);
    int exp;
    string req;
    @(negedge clk);
    clr_n = c; go_n = g; down = d;
    if (!c)      begin exp = 0;              req = "R1"; end
    else if (g)  begin exp = mdl;            req = "R2"; end
    else if (!d) begin exp = (mdl + 1) % 4;  req = (mdl == 3) ? "R4" : "R3"; end
    else         begin exp = (mdl + 3) % 4;  req = (mdl == 0) ? "R6" : "R5"; end
    @(posedge clk);
    #1;
    mdl = exp;
    total++;
    if (count !== 2'(exp)) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, count, exp);
    end
  endtask

  // R7: wiggle inputs mid-cycle, count must not move before next edge
  task automatic wiggle();
    #2;
    clr_n = 1'b0; go_n = 1'b0; down = ~down;
    #1;
    clr_n = 1'b1; down = ~down;
    total++;
    if (count !== 2'(mdl)) begin
      bad++;
      $display("FAIL R7 actual=%0d expected=%0d", count, mdl);
    end
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(1'b0, 1'b1, 1'b1);          // R1 reset state
    step(1'b1, 1'b1, 1'b0);          // R2 hold at 0
    step(1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0);  // R3, R4 wrap
    wiggle();
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b1);  // R5, R6 wrap
    wiggle();
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 8; c++) begin
        step(1'b0, 1'b0, 1'b0);
        for (int k = 0; k < s; k++) step(1'b1, 1'b0, 1'b0);
        step(c[2], c[1], c[0]);
        wiggle();
      end
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule